// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is a two-sided mailbox between a host bus and the small embedded CPU of a PC-style keyboard controller. The host sees two byte ports, chosen by one address bit: a data port and a status/command port. The keyboard CPU sees a data buffer and a status register. The block stores one byte travelling from host to CPU (the input byte) and one byte travelling from CPU to host (the output byte).

Two full flags track the bytes. Each one is set by a write on one side and cleared only when the other side reads. A command/data flag records which host port the last host write went to, so the CPU firmware can tell commands from data. The block drives a host-side keyboard interrupt while the output byte waits. It drives a CPU-side interrupt while the input byte waits. Each interrupt has its own enable input.

All accesses are one-cycle strobes on a single clock. Flag and byte updates take effect at the clock edge that samples the strobe. Read data is combinational.

Top module: `kbc_host_mailbox`

## Requirements
- R1: After synchronous reset the status byte is 00h, both stored bytes are 00h and both interrupts are low.
- R2: A CPU data write (`cpu_wr_data`) stores `cpu_wdata` as the output byte and sets the output-full flag (status bit 0) at that edge. While `host_addr`=0 the host read data shows the output byte.
- R3: A host read of the data port (`host_rd` with `host_addr`=0) clears the output-full flag at that edge.
- R4: Any host write stores `host_wdata` as the input byte (`cpu_in_data`), sets the input-full flag (status bit 1) and loads the command/data flag (status bit 3) with `host_addr`: 1 means command, 0 means data.
- R5: A CPU read of the input buffer (`cpu_rd_data`) clears the input-full flag.
- R6: The status byte has output-full in bit 0, input-full in bit 1 and command/data in bit 3. It reads the same on `cpu_status` and on the host port when `host_addr`=1. A host read of the status port changes no flag.
- R7: A CPU status write (`cpu_wr_status`) loads only bits 7..4 and 2 from `cpu_wdata`. Bits 0, 1 and 3 can be changed only through buffer accesses. The host has no path that writes the status byte.
- R8: `host_kbd_irq` is high exactly when the output-full flag is set and `kbd_irq_en` is high.
- R9: `cpu_ibf_irq` is high exactly when the input-full flag is set and `ibf_irq_en` is high.
- R10: A host write while the input-full flag is set overwrites the input byte and the command/data flag. A CPU data write while the output-full flag is set overwrites the output byte. Neither case raises any error indication.
- R11: When a set and a clear of the same full flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1 | Host port select: 0 data, 1 status/command |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data: output byte or status byte |
| host_kbd_irq | output | 1 | Host keyboard interrupt |
| kbd_irq_en | input | 1 | Enable for host_kbd_irq |
| cpu_wr_data | input | 1 | CPU write strobe for the output byte |
| cpu_rd_data | input | 1 | CPU read strobe for the input byte |
| cpu_wr_status | input | 1 | CPU write strobe for the user bits of the status byte |
| cpu_wdata | input | 8 | CPU write data |
| cpu_in_data | output | 8 | Input byte as seen by the CPU |
| cpu_status | output | 8 | Status byte as seen by the CPU |
| cpu_ibf_irq | output | 1 | CPU input-buffer interrupt |
| ibf_irq_en | input | 1 | Enable for cpu_ibf_irq |

## Verification
Either full flag can be set and cleared in the same cycle. The output-full flag sees this when a CPU data write meets a host data-port read. The input-full flag sees this when a host write meets a CPU buffer read. Directed cycles drive both strobes together, and a long randomized stretch raises every strobe with high probability so these collisions happen often. After each edge, a behavioural model in the bench that gives the set precedence is compared against the status byte, both interrupts and both data paths.

// File: rtl/kbc_mbox_pkg.sv
package kbc_mbox_pkg;

    localparam int BYTE_W  = 8;
    localparam int OBF_BIT = 0;
    localparam int IBF_BIT = 1;
    localparam int CD_BIT  = 3;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t FLAG_MASK = byte_t'((1 << OBF_BIT) | (1 << IBF_BIT) | (1 << CD_BIT));
    localparam byte_t USER_MASK = ~FLAG_MASK;

    typedef enum logic {
        PORT_DATA = 1'b0,
        PORT_CMD  = 1'b1
    } port_sel_e;

    typedef struct packed {
        logic obf;
        logic ibf;
        logic cd;
    } flags_t;

    function automatic byte_t pack_status(flags_t f, byte_t user);
        byte_t r;
        r          = user & USER_MASK;
        r[OBF_BIT] = f.obf;
        r[IBF_BIT] = f.ibf;
        r[CD_BIT]  = f.cd;
        return r;
    endfunction

endpackage

// File: rtl/kbc_sticky_flag.sv
module kbc_sticky_flag #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    always_ff @(posedge clk) begin
        if (rst)
            q_o <= RESET_VAL;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o); // R11

    AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !q_o); // R5

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(q_o)); // R6

endmodule

// File: rtl/kbc_load_reg.sv
module kbc_load_reg #(
    parameter int          W    = 8,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst)
            q_o <= '0;
        else if (ld_i)
            q_o <= d_i & MASK;
    end

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ld_i |=> $stable(q_o)); // R7

    AST_REG_LOAD: assert property (@(posedge clk) disable iff (rst)
        ld_i |=> (q_o == ($past(d_i) & MASK))); // R10

endmodule

// File: rtl/kbc_host_mailbox.sv
module kbc_host_mailbox
    import kbc_mbox_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic        host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        host_kbd_irq,
    input  logic        kbd_irq_en,
    input  logic        cpu_wr_data,
    input  logic        cpu_rd_data,
    input  logic        cpu_wr_status,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_in_data,
    output logic [7:0]  cpu_status,
    output logic        cpu_ibf_irq,
    input  logic        ibf_irq_en
);

    port_sel_e host_port;
    flags_t    flags;
    byte_t     out_byte;
    byte_t     user_bits;
    logic      host_data_rd;
    logic      cd_q;

    assign host_port    = port_sel_e'(host_addr);
    assign host_data_rd = host_rd && (host_port == PORT_DATA);

    // Host-to-CPU path
    kbc_load_reg #(.W(BYTE_W)) u_in_byte (
        .clk(clk), .rst(rst), .ld_i(host_wr), .d_i(host_wdata), .q_o(cpu_in_data)
    );

    kbc_load_reg #(.W(1)) u_cd (
        .clk(clk), .rst(rst), .ld_i(host_wr), .d_i(host_addr), .q_o(cd_q)
    );

    kbc_sticky_flag u_ibf (
        .clk(clk), .rst(rst), .set_i(host_wr), .clr_i(cpu_rd_data), .q_o(flags.ibf)
    );

    // CPU-to-host path
    kbc_load_reg #(.W(BYTE_W)) u_out_byte (
        .clk(clk), .rst(rst), .ld_i(cpu_wr_data), .d_i(cpu_wdata), .q_o(out_byte)
    );

    kbc_sticky_flag u_obf (
        .clk(clk), .rst(rst), .set_i(cpu_wr_data), .clr_i(host_data_rd), .q_o(flags.obf)
    );

    // CPU-owned user bits of the status byte
    kbc_load_reg #(.W(BYTE_W), .MASK(USER_MASK)) u_user (
        .clk(clk), .rst(rst), .ld_i(cpu_wr_status), .d_i(cpu_wdata), .q_o(user_bits)
    );

    assign flags.cd = cd_q;

    always_comb begin
        cpu_status   = pack_status(flags, user_bits);
        host_rdata   = (host_port == PORT_CMD) ? cpu_status : out_byte;
        host_kbd_irq = flags.obf && kbd_irq_en;
        cpu_ibf_irq  = flags.ibf && ibf_irq_en;
    end

    AST_CD_FROM_ADDR: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> (cpu_status[CD_BIT] == $past(host_addr))); // R4

    AST_HOST_IRQ_NEEDS_OBF: assert property (@(posedge clk) disable iff (rst)
        host_kbd_irq |-> cpu_status[OBF_BIT]); // R8

    AST_CPU_IRQ_NEEDS_IBF: assert property (@(posedge clk) disable iff (rst)
        cpu_ibf_irq |-> cpu_status[IBF_BIT]); // R9

    AST_DATA_RD_CLEARS_OBF: assert property (@(posedge clk) disable iff (rst)
        (host_data_rd && !cpu_wr_data) |=> !cpu_status[OBF_BIT]); // R3

    AST_STATUS_RD_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr && !host_wr && !cpu_wr_data && !cpu_rd_data)
        |=> $stable(cpu_status[IBF_BIT:OBF_BIT])); // R6

endmodule

// File: tb/kbc_host_mailbox_tb_top.sv
module kbc_host_mailbox_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       host_wr, host_rd, host_addr;
    logic [7:0] host_wdata, host_rdata;
    logic       host_kbd_irq, kbd_irq_en;
    logic       cpu_wr_data, cpu_rd_data, cpu_wr_status;
    logic [7:0] cpu_wdata, cpu_in_data, cpu_status;
    logic       cpu_ibf_irq, ibf_irq_en;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    bit       m_obf, m_ibf, m_cd;
    bit [7:0] m_user, m_in, m_out;

    always #5 clk = ~clk;

    kbc_host_mailbox dut_i (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_kbd_irq(host_kbd_irq), .kbd_irq_en(kbd_irq_en),
        .cpu_wr_data(cpu_wr_data), .cpu_rd_data(cpu_rd_data),
        .cpu_wr_status(cpu_wr_status), .cpu_wdata(cpu_wdata),
        .cpu_in_data(cpu_in_data), .cpu_status(cpu_status),
        .cpu_ibf_irq(cpu_ibf_irq), .ibf_irq_en(ibf_irq_en)
    );

    function automatic bit [7:0] m_status();
        return (m_user & 8'hF4) | {4'b0, m_cd, 1'b0, m_ibf, m_obf};
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "status (R6)", cpu_status, m_status());
        check(tag, "in byte (R4)", cpu_in_data, m_in);
        check(tag, "host irq (R8)", host_kbd_irq, m_obf & kbd_irq_en);
        check(tag, "cpu irq (R9)", cpu_ibf_irq, m_ibf & ibf_irq_en);
        check(tag, "host rdata (R2)", host_rdata, host_addr ? m_status() : m_out);
    endtask

    // Drive one cycle of strobes; update model at the edge; compare after it.
    task automatic cyc(input string tag, input bit hw, input bit hr, input bit ha,
                       input bit [7:0] hd, input bit cwd, input bit crd,
                       input bit cws, input bit [7:0] cd);
        bit s_obf, c_obf, s_ibf, c_ibf;
        host_wr = hw; host_rd = hr; host_addr = ha; host_wdata = hd;
        cpu_wr_data = cwd; cpu_rd_data = crd; cpu_wr_status = cws; cpu_wdata = cd;
        @(posedge clk);
        s_obf = cwd; c_obf = hr && !ha;
        s_ibf = hw;  c_ibf = crd;
        m_obf = s_obf ? 1'b1 : (c_obf ? 1'b0 : m_obf);
        m_ibf = s_ibf ? 1'b1 : (c_ibf ? 1'b0 : m_ibf);
        if (hw)  begin m_in = hd; m_cd = ha; end
        if (cwd) m_out = cd;
        if (cws) m_user = cd & 8'hF4;
        #1;
        host_wr = 0; host_rd = 0; cpu_wr_data = 0; cpu_rd_data = 0; cpu_wr_status = 0;
        compare_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1; host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
        cpu_wr_data = 0; cpu_rd_data = 0; cpu_wr_status = 0; cpu_wdata = 0;
        kbd_irq_en = 1; ibf_irq_en = 1;
        cpu_wr_status = 1; cpu_wdata = 8'hFF; host_wr = 1; // strobes ignored in reset
        repeat (3) @(posedge clk);
        #1; rst = 0; host_wr = 0; cpu_wr_status = 0;
        m_obf = 0; m_ibf = 0; m_cd = 0; m_user = 0; m_in = 0; m_out = 0;
        check("R1", "status", cpu_status, 0);
        check("R1", "host irq", host_kbd_irq, 0);
        check("R1", "cpu irq", cpu_ibf_irq, 0);
        check("R1", "out byte", host_rdata, 0);
        check("R1", "in byte", cpu_in_data, 0);

        cyc("R2 cpu write", 0,0,0,8'h00, 1,0,0,8'hA5);
        check("R2", "obf set", cpu_status[0], 1);
        check("R2", "out byte", host_rdata, 8'hA5);
        cyc("R10 cpu overwrite", 0,0,0,8'h00, 1,0,0,8'h3C);
        check("R10", "out byte", host_rdata, 8'h3C);
        cyc("R6 status read", 0,1,1,8'h00, 0,0,0,8'h00);
        check("R6", "obf kept", cpu_status[0], 1);
        cyc("R3 data read", 0,1,0,8'h00, 0,0,0,8'h00);
        check("R3", "obf clear", cpu_status[0], 0);

        cyc("R4 host cmd write", 1,0,1,8'h60, 0,0,0,8'h00);
        check("R4", "cd=cmd", cpu_status[3], 1);
        check("R4", "ibf", cpu_status[1], 1);
        cyc("R10 host overwrite", 1,0,0,8'h47, 0,0,0,8'h00);
        check("R10", "cd=data", cpu_status[3], 0);
        check("R10", "in byte", cpu_in_data, 8'h47);
        cyc("R5 cpu read", 0,0,0,8'h00, 0,1,0,8'h00);
        check("R5", "ibf clear", cpu_status[1], 0);

        cyc("R7 status write", 0,0,0,8'h00, 0,0,1,8'hFF);
        check("R7", "status", cpu_status, 8'hF4);
        cyc("R7 status write low", 0,0,0,8'h00, 0,0,1,8'h0B);
        check("R7", "status", cpu_status, 8'h00);

        cyc("R11 obf collide prep", 0,0,0,8'h00, 1,0,0,8'h11);
        cyc("R11 obf collide", 0,1,0,8'h00, 1,0,0,8'h22);
        check("R11", "obf", cpu_status[0], 1);
        cyc("R11 ibf collide prep", 1,0,0,8'h33, 0,0,0,8'h00);
        cyc("R11 ibf collide", 1,0,1,8'h44, 0,1,0,8'h00);
        check("R11", "ibf", cpu_status[1], 1);

        kbd_irq_en = 0; ibf_irq_en = 0; #1;
        compare_all("R8 R9 enables off");
        check("R8", "masked", host_kbd_irq, 0);
        check("R9", "masked", cpu_ibf_irq, 0);
        kbd_irq_en = 1; ibf_irq_en = 1; #1;
        check("R8", "unmasked", host_kbd_irq, 1);
        check("R9", "unmasked", cpu_ibf_irq, 1);

        for (int i = 0; i < 2000; i++) begin
            kbd_irq_en = 1'($urandom); ibf_irq_en = 1'($urandom);
            cyc("R11 random", 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
                1'($urandom), 1'($urandom), ($urandom % 4) == 0, 8'($urandom));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule